// File: doc/BRIEF.md
# Program-Ordered Memory Access Queue

This block holds every memory instruction of an out-of-order core (loads, stores and atomics) in one queue, in the order the instructions were dispatched. Dispatch appends an entry that records the instruction's reorder-buffer slot, its access kind and its size. Later, the integer ALU writes the computed address and the store data into the entry, and that write marks the entry valid. Only the oldest entry may go to the load-store unit, and it goes only once it is valid. Because there is no forwarding between entries and no disambiguation, strict head-only issue is what keeps memory accesses correct.

A load at the head leaves as soon as its address is known, even though the load may still be speculative. A store or an atomic at the head waits until its reorder-buffer slot is the oldest instruction in the machine. The load-store unit takes one request and signals completion after a variable latency. When a load or an atomic completes, its data goes back to the owning reorder-buffer slot, and that write marks the slot ready. When a branch mispredicts, the tail pointer rolls back to a snapshot taken when the branch was dispatched. An access already in flight for a discarded entry completes without effect.

Top module: `mem_order_queue`

## Requirements
- R1: When `alloc_req` is high and the allocation is not blocked (see R2), a clock edge appends one entry at the tail, and `alloc_ptr` advances by one modulo 2*DEPTH. `alloc_ptr` carries a wrap bit above the slot index, and its low bits name the slot the new entry takes. `alloc_full` is high exactly when DEPTH entries are held.
- R2: An allocation request is ignored, and leaves `alloc_ptr` unchanged, in any cycle where `alloc_full` or `flush_valid` is high.
- R3: An entry is never sent to memory before `agu_we` has written its slot with an address.
- R4: Only the head entry may issue, so a younger entry never overtakes an older one. `mem_req` is a one-cycle pulse, raised in the cycle after the edge at which the issue conditions hold.
- R5: A load (kind 0) at the head issues whatever the value of `rob_head`.
- R6: A store (kind 1) or an atomic (kind 2) at the head issues only when its reorder-buffer slot equals `rob_head`.
- R7: At most one access is outstanding. No `mem_req` is raised between a request and its `mem_done`, and this includes a request whose entry has been discarded.
- R8: When `mem_done` arrives for a load or an atomic, `res_valid` pulses in the next cycle. It carries the owning `res_rob` and `res_data` equal to `mem_rdata`, and the entry leaves the queue. A store's completion raises no `res_valid`.
- R9: A store keeps its queue slot until its `mem_done` arrives.
- R10: `flush_valid` sets the tail to `flush_ptr`, and this discards every entry from `flush_ptr` up to the old tail. Discarded entries never issue. If the head entry that is in flight is discarded, its `mem_done` produces no result.
- R11: After reset the queue is empty, `alloc_ptr` is 0, and neither `mem_req` nor `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Dispatch asks for a new entry |
| alloc_kind | input | 2 | 0 load, 1 store, 2 atomic |
| alloc_size | input | 2 | Access size code, passed through to memory |
| alloc_rob | input | ROB_W | Reorder-buffer slot of the instruction |
| alloc_full | output | 1 | Queue holds DEPTH entries |
| alloc_ptr | output | IDX_W+1 | Tail pointer with wrap bit; the low bits are the slot of the next entry |
| agu_we | input | 1 | Address write from the integer ALU |
| agu_slot | input | IDX_W | Queue slot being written |
| agu_addr | input | ADDR_W | Computed address |
| agu_data | input | DATA_W | Store data |
| rob_head | input | ROB_W | Slot of the oldest reorder-buffer entry |
| flush_valid | input | 1 | Misprediction rollback |
| flush_ptr | input | IDX_W+1 | Tail snapshot taken at the branch's dispatch |
| mem_req | output | 1 | Request pulse to the load-store unit |
| mem_kind | output | 2 | Kind of the request |
| mem_size | output | 2 | Size of the request |
| mem_addr | output | ADDR_W | Address of the request |
| mem_wdata | output | DATA_W | Store data of the request |
| mem_rob | output | ROB_W | Reorder-buffer slot of the request |
| mem_done | input | 1 | The outstanding access has completed |
| mem_rdata | input | DATA_W | Data read by the completed access |
| res_valid | output | 1 | Result write to the reorder buffer |
| res_rob | output | ROB_W | Target reorder-buffer slot |
| res_data | output | DATA_W | Result data |

## Verification
Directed sequences each isolate one ordering rule, measured against the request and result counts. A lone load with `rob_head` pointing elsewhere separates speculative load issue from the ordering of stores. A store followed by a load, with the head held back, shows that nothing passes a blocked head. A queue filled with stores shows whether the full flag and slot release wait for store completion. A rollback that lands exactly on an in-flight head tells whether the late completion is suppressed. A long random mix of kinds, latencies, out-of-order address writes, head movement and partial rollbacks is then compared every cycle with a queue-based model. That comparison exposes wrong truncation points, lost pops and misrouted results.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam logic [1:0] KIND_LOAD   = 2'd0;
  localparam logic [1:0] KIND_STORE  = 2'd1;
  localparam logic [1:0] KIND_ATOMIC = 2'd2;

  // Loads may leave speculatively; everything else needs the oldest slot.
  function automatic logic needs_commit_order(input logic [1:0] kind);
    return kind != KIND_LOAD;
  endfunction

  // Loads and atomics return data to the reorder buffer.
  function automatic logic returns_data(input logic [1:0] kind);
    return kind != KIND_STORE;
  endfunction
endpackage

// File: rtl/lsq_ptrs.sv
module lsq_ptrs #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [PTR_W-1:0] flush_ptr,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] tail_ptr,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

  logic [PTR_W-1:0] level;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else begin
      if (pop)
        head_ptr <= head_ptr + PTR_W'(1);
      if (flush)
        tail_ptr <= flush_ptr;
      else if (push)
        tail_ptr <= tail_ptr + PTR_W'(1);
    end
  end

  assign level = tail_ptr - head_ptr;
  assign full  = (level == FULL_CNT);
  assign empty = (level == '0);
endmodule

// File: rtl/lsq_store.sv
module lsq_store #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int ROB_W  = 5,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [ROB_W-1:0]  alloc_rob,
  input  logic [1:0]        alloc_kind,
  input  logic [1:0]        alloc_size,
  input  logic              agu_we,
  input  logic [IDX_W-1:0]  agu_idx,
  input  logic [ADDR_W-1:0] agu_addr,
  input  logic [DATA_W-1:0] agu_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [ROB_W-1:0]  rd_rob,
  output logic [1:0]        rd_kind,
  output logic [1:0]        rd_size,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  // Payload arrays carry no reset so they map onto distributed RAM.
  logic [ROB_W-1:0]  rob_mem  [DEPTH];
  logic [1:0]        kind_mem [DEPTH];
  logic [1:0]        size_mem [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [DEPTH-1:0]  ready_q;

  always_ff @(posedge clk) begin
    if (alloc_we) begin
      rob_mem[alloc_idx]  <= alloc_rob;
      kind_mem[alloc_idx] <= alloc_kind;
      size_mem[alloc_idx] <= alloc_size;
    end
  end

  always_ff @(posedge clk) begin
    if (agu_we) begin
      addr_mem[agu_idx] <= agu_addr;
      data_mem[agu_idx] <= agu_data;
    end
  end

  // Per-slot address-valid flags: cleared on allocation, set by the ALU.
  for (genvar s = 0; s < DEPTH; s++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        ready_q[s] <= 1'b0;
      else if (alloc_we && alloc_idx == IDX_W'(s))
        ready_q[s] <= 1'b0;
      else if (agu_we && agu_idx == IDX_W'(s))
        ready_q[s] <= 1'b1;
    end
  end

  assign rd_valid = ready_q[rd_idx];
  assign rd_rob   = rob_mem[rd_idx];
  assign rd_kind  = kind_mem[rd_idx];
  assign rd_size  = size_mem[rd_idx];
  assign rd_addr  = addr_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];
endmodule

// File: rtl/lsq_issue.sv
module lsq_issue
  import lsq_pkg::*;
#(
  parameter int ROB_W  = 5,
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              empty,
  input  logic [PTR_W-1:0]  head_ptr,
  input  logic              hd_valid,
  input  logic [ROB_W-1:0]  hd_rob,
  input  logic [1:0]        hd_kind,
  input  logic [1:0]        hd_size,
  input  logic [ADDR_W-1:0] hd_addr,
  input  logic [DATA_W-1:0] hd_data,
  input  logic [ROB_W-1:0]  rob_head,
  input  logic              flush,
  input  logic [PTR_W-1:0]  flush_ptr,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pop,
  output logic              mem_req,
  output logic [1:0]        mem_kind,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ROB_W-1:0]  mem_rob,
  output logic              res_valid,
  output logic [ROB_W-1:0]  res_rob,
  output logic [DATA_W-1:0] res_data
);
  logic busy_q;   // one access outstanding at the unit
  logic orphan_q; // outstanding access belongs to a discarded entry
  logic head_kill, finish, order_ok, launch;

  assign head_kill = flush && busy_q && !orphan_q && (flush_ptr == head_ptr);
  assign finish    = busy_q && mem_done;
  assign pop       = finish && !orphan_q && !head_kill;
  assign order_ok  = !needs_commit_order(hd_kind) || (hd_rob == rob_head);
  assign launch    = !busy_q && !flush && !empty && hd_valid && order_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      orphan_q  <= 1'b0;
      mem_req   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      mem_req   <= launch;
      res_valid <= pop && returns_data(hd_kind);
      if (launch)
        busy_q <= 1'b1;
      else if (finish)
        busy_q <= 1'b0;
      if (finish)
        orphan_q <= 1'b0;
      else if (head_kill)
        orphan_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (launch) begin
      mem_kind  <= hd_kind;
      mem_size  <= hd_size;
      mem_addr  <= hd_addr;
      mem_wdata <= hd_data;
      mem_rob   <= hd_rob;
    end
    if (pop) begin
      res_rob  <= hd_rob;
      res_data <= mem_rdata;
    end
  end
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue #(
  parameter int DEPTH  = 8,
  parameter int ROB_W  = 5,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic [1:0]        alloc_kind,
  input  logic [1:0]        alloc_size,
  input  logic [ROB_W-1:0]  alloc_rob,
  output logic              alloc_full,
  output logic [PTR_W-1:0]  alloc_ptr,
  input  logic              agu_we,
  input  logic [IDX_W-1:0]  agu_slot,
  input  logic [ADDR_W-1:0] agu_addr,
  input  logic [DATA_W-1:0] agu_data,
  input  logic [ROB_W-1:0]  rob_head,
  input  logic              flush_valid,
  input  logic [PTR_W-1:0]  flush_ptr,
  output logic              mem_req,
  output logic [1:0]        mem_kind,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ROB_W-1:0]  mem_rob,
  input  logic              mem_done,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic [ROB_W-1:0]  res_rob,
  output logic [DATA_W-1:0] res_data
);
  logic             push, pop, empty;
  logic [PTR_W-1:0] head_ptr, tail_ptr;
  logic             hd_valid;
  logic [ROB_W-1:0] hd_rob;
  logic [1:0]       hd_kind, hd_size;
  logic [ADDR_W-1:0] hd_addr;
  logic [DATA_W-1:0] hd_data;

  assign push      = alloc_req && !alloc_full && !flush_valid;
  assign alloc_ptr = tail_ptr;

  lsq_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) ptrs_i (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .flush(flush_valid), .flush_ptr(flush_ptr),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr),
    .full(alloc_full), .empty(empty)
  );

  lsq_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ROB_W(ROB_W),
              .ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst(rst),
    .alloc_we(push), .alloc_idx(tail_ptr[IDX_W-1:0]),
    .alloc_rob(alloc_rob), .alloc_kind(alloc_kind), .alloc_size(alloc_size),
    .agu_we(agu_we), .agu_idx(agu_slot), .agu_addr(agu_addr), .agu_data(agu_data),
    .rd_idx(head_ptr[IDX_W-1:0]),
    .rd_valid(hd_valid), .rd_rob(hd_rob), .rd_kind(hd_kind),
    .rd_size(hd_size), .rd_addr(hd_addr), .rd_data(hd_data)
  );

  lsq_issue #(.ROB_W(ROB_W), .PTR_W(PTR_W),
              .ADDR_W(ADDR_W), .DATA_W(DATA_W)) issue_i (
    .clk(clk), .rst(rst), .empty(empty), .head_ptr(head_ptr),
    .hd_valid(hd_valid), .hd_rob(hd_rob), .hd_kind(hd_kind),
    .hd_size(hd_size), .hd_addr(hd_addr), .hd_data(hd_data),
    .rob_head(rob_head), .flush(flush_valid), .flush_ptr(flush_ptr),
    .mem_done(mem_done), .mem_rdata(mem_rdata), .pop(pop),
    .mem_req(mem_req), .mem_kind(mem_kind), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rob(mem_rob),
    .res_valid(res_valid), .res_rob(res_rob), .res_data(res_data)
  );
endmodule

// File: rtl/lsq_checker.sv
module lsq_checker #(
  parameter int ROB_W = 5,
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_req,
  input logic             alloc_full,
  input logic [PTR_W-1:0] alloc_ptr,
  input logic             flush_valid,
  input logic [PTR_W-1:0] flush_ptr,
  input logic [ROB_W-1:0] rob_head,
  input logic             mem_req,
  input logic [1:0]       mem_kind,
  input logic [ROB_W-1:0] mem_rob,
  input logic             mem_done,
  input logic             res_valid
);
  logic       open_q;
  logic [1:0] open_kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      open_kind_q <= 2'd0;
    end else if (mem_req) begin
      open_q      <= 1'b1;
      open_kind_q <= mem_kind;
    end else if (mem_done) begin
      open_q <= 1'b0;
    end
  end

  // R2
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (alloc_full && alloc_req && !flush_valid) |=> alloc_ptr == $past(alloc_ptr));
  // R10
  p_flush_tail_r10: assert property (@(posedge clk) disable iff (rst)
    flush_valid |=> alloc_ptr == $past(flush_ptr));
  // R6
  p_store_order_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_kind != 2'd0) |-> mem_rob == $past(rob_head));
  // R7
  p_single_open_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !open_q);
  // R4
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R8
  p_result_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(mem_done) && $past(open_q)));
  // R8
  p_store_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_done && open_q && open_kind_q == 2'd1) |=> !res_valid);
endmodule

bind mem_order_queue lsq_checker #(.ROB_W(ROB_W), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_full(alloc_full),
  .alloc_ptr(alloc_ptr), .flush_valid(flush_valid), .flush_ptr(flush_ptr),
  .rob_head(rob_head), .mem_req(mem_req), .mem_kind(mem_kind),
  .mem_rob(mem_rob), .mem_done(mem_done), .res_valid(res_valid)
);

// File: tb/mem_order_queue_tb.sv
module mem_order_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int ROB_W = 5;
  localparam int IDX_W = 3;
  localparam int PTR_W = 4;
  localparam int PMOD  = 2 * DEPTH;
  localparam logic [31:0] RKEY = 32'h5A5A_0F0F;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_req = 0; logic [1:0] alloc_kind = 0, alloc_size = 0;
  logic [ROB_W-1:0] alloc_rob = 0;
  logic alloc_full; logic [PTR_W-1:0] alloc_ptr;
  logic agu_we = 0; logic [IDX_W-1:0] agu_slot = 0;
  logic [31:0] agu_addr = 0, agu_data = 0;
  logic [ROB_W-1:0] rob_head = 0;
  logic flush_valid = 0; logic [PTR_W-1:0] flush_ptr = 0;
  logic mem_req; logic [1:0] mem_kind, mem_size;
  logic [31:0] mem_addr, mem_wdata; logic [ROB_W-1:0] mem_rob;
  logic mem_done = 0; logic [31:0] mem_rdata = 0;
  logic res_valid; logic [ROB_W-1:0] res_rob; logic [31:0] res_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_order_queue #(.DEPTH(DEPTH), .ROB_W(ROB_W)) dut_i (.*);

  int checks = 0, errors = 0, cycles = 0;
  int req_cnt = 0, res_cnt = 0;
  logic [ROB_W-1:0] last_rob; logic [31:0] last_data;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct {
    int ptr; logic [ROB_W-1:0] rob; logic [1:0] kind, size;
    bit vld; logic [31:0] addr, data;
  } ent_t;
  ent_t mq[$];
  int h_ptr = 0, t_ptr = 0;
  bit m_busy = 0, m_orphan = 0;
  bit e_req = 0, e_res = 0;
  logic [1:0] e_kind; logic [ROB_W-1:0] e_rob, e_rrob; logic [31:0] e_addr, e_data, e_rdata;

  task automatic model_step();
    bit kill, fin, launch, full0; int keep;
    if (rst) begin
      mq.delete(); h_ptr = 0; t_ptr = 0; m_busy = 0; m_orphan = 0;
      e_req = 0; e_res = 0; return;
    end
    full0  = (mq.size() == DEPTH);
    kill   = flush_valid && m_busy && !m_orphan && (int'(flush_ptr) == h_ptr);
    fin    = m_busy && mem_done;
    launch = !m_busy && !flush_valid && mq.size() > 0 && mq[0].vld &&
             (mq[0].kind == 2'd0 || mq[0].rob == rob_head);
    e_req = launch; e_res = 0;
    if (launch) begin
      e_kind = mq[0].kind; e_rob = mq[0].rob; e_addr = mq[0].addr; e_data = mq[0].data;
    end
    if (flush_valid) begin
      keep = (int'(flush_ptr) - h_ptr + PMOD) % PMOD;
      while (mq.size() > keep) void'(mq.pop_back());
    end
    if (fin && !m_orphan && !kill) begin
      if (mq[0].kind != 2'd1) begin e_res = 1; e_rrob = mq[0].rob; e_rdata = mem_rdata; end
      void'(mq.pop_front()); h_ptr = (h_ptr + 1) % PMOD;
    end
    if (launch) m_busy = 1; else if (fin) m_busy = 0;
    if (fin) m_orphan = 0; else if (kill) m_orphan = 1;
    if (agu_we)
      foreach (mq[i]) if (mq[i].ptr % DEPTH == int'(agu_slot)) begin
        mq[i].vld = 1; mq[i].addr = agu_addr; mq[i].data = agu_data;
      end
    if (alloc_req && !full0 && !flush_valid) begin
      mq.push_back('{t_ptr, alloc_rob, alloc_kind, alloc_size, 1'b0, 32'h0, 32'h0});
      t_ptr = (t_ptr + 1) % PMOD;
    end
    if (flush_valid) t_ptr = int'(flush_ptr);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst) begin
      if (mem_req) req_cnt++;
      if (res_valid) begin res_cnt++; last_rob = res_rob; last_data = res_data; end
    end
    model_step();
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) if (!rst) begin
    chk(mem_req == e_req, "R4 R5 R6 R7 mem_req", mem_req, e_req);
    if (e_req) begin
      chk(mem_addr == e_addr, "R4 mem_addr", mem_addr, e_addr);
      chk(mem_wdata == e_data, "R4 mem_wdata", mem_wdata, e_data);
      chk(mem_kind == e_kind && mem_rob == e_rob, "R4 mem_kind/rob",
          {mem_kind, mem_rob}, {e_kind, e_rob});
    end
    chk(res_valid == e_res, "R8 R10 res_valid", res_valid, e_res);
    if (e_res)
      chk(res_rob == e_rrob && res_data == e_rdata, "R8 res_rob/data",
          {res_rob, res_data}, {e_rrob, e_rdata});
    chk(alloc_full == (mq.size() == DEPTH), "R1 R2 R9 alloc_full", alloc_full, mq.size() == DEPTH);
    chk(int'(alloc_ptr) == t_ptr, "R1 R2 R10 alloc_ptr", alloc_ptr, t_ptr);
  end

  // ---------------- load-store unit responder ----------------
  int lsu_lat = 3; bit lsu_rand = 0;
  bit pend = 0; int cnt = 0; logic [31:0] p_addr;
  always @(negedge clk) begin
    if (rst) begin pend = 0; mem_done = 0; end
    else begin
      mem_done = 0;
      if (pend) begin
        cnt--;
        if (cnt == 0) begin mem_done = 1; mem_rdata = p_addr ^ RKEY; pend = 0; end
      end
      if (mem_req) begin
        pend = 1; p_addr = mem_addr;
        cnt = lsu_rand ? int'($urandom_range(1, 5)) : lsu_lat;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_alloc(input logic [1:0] k, input logic [ROB_W-1:0] r, output logic [PTR_W-1:0] p);
    p = alloc_ptr;
    alloc_req = 1; alloc_kind = k; alloc_size = 2'd2; alloc_rob = r;
    step(1); alloc_req = 0;
  endtask

  task automatic do_agu(input logic [PTR_W-1:0] p, input logic [31:0] a);
    agu_we = 1; agu_slot = p[IDX_W-1:0]; agu_addr = a; agu_data = ~a;
    step(1); agu_we = 0;
  endtask

  initial begin
    logic [PTR_W-1:0] pa, pb, pc, pd, ps[DEPTH], pt;
    int r0, q0;
    step(3); rst = 0;
    chk(mem_req == 0 && res_valid == 0, "R11 reset outputs", {mem_req, res_valid}, 0);
    chk(alloc_ptr == 0 && alloc_full == 0, "R11 reset pointer", {alloc_full, alloc_ptr}, 0);

    // Lone load, rob_head elsewhere.
    rob_head = 5'd20; q0 = req_cnt; r0 = res_cnt;
    do_alloc(2'd0, 5'd3, pa); step(3);
    chk(req_cnt == q0, "R3 no issue before address", req_cnt, q0);
    do_agu(pa, 32'h100); step(8);
    chk(req_cnt == q0 + 1, "R5 speculative load issued", req_cnt, q0 + 1);
    chk(res_cnt == r0 + 1 && last_rob == 5'd3, "R8 load result rob", last_rob, 3);
    chk(last_data == (32'h100 ^ RKEY), "R8 load result data", last_data, 32'h100 ^ RKEY);

    // Store then load; the head store waits for its rob slot.
    rob_head = 5'd1; q0 = req_cnt; r0 = res_cnt;
    do_alloc(2'd1, 5'd7, pa); do_alloc(2'd0, 5'd8, pb);
    do_agu(pa, 32'h200); do_agu(pb, 32'h204); step(6);
    chk(req_cnt == q0, "R6 R4 blocked store holds queue", req_cnt, q0);
    rob_head = 5'd7; step(12);
    chk(req_cnt == q0 + 2, "R6 store then load issued", req_cnt, q0 + 2);
    chk(res_cnt == r0 + 1 && last_rob == 5'd8, "R8 only load returns", res_cnt, r0 + 1);

    // Fill with stores.
    rob_head = 5'd0; lsu_lat = 6;
    for (int i = 0; i < DEPTH; i++) do_alloc(2'd1, 5'd0, ps[i]);
    chk(alloc_full == 1, "R1 full after DEPTH allocations", alloc_full, 1);
    pt = alloc_ptr; do_alloc(2'd0, 5'd9, pc);
    chk(alloc_ptr == pt, "R2 allocation ignored while full", alloc_ptr, pt);
    q0 = req_cnt; do_agu(ps[0], 32'h300); step(4);
    chk(req_cnt == q0 + 1 && alloc_full == 1, "R9 store in flight keeps slot", alloc_full, 1);
    step(4);
    chk(alloc_full == 0, "R9 slot freed after completion", alloc_full, 0);
    for (int i = 1; i < DEPTH; i++) do_agu(ps[i], 32'h300 + 32'(i * 4));
    step(70);

    // Rollback onto an in-flight head.
    lsu_lat = 8; rob_head = 5'd31; r0 = res_cnt;
    do_alloc(2'd0, 5'd1, pa); do_alloc(2'd0, 5'd2, pb); do_alloc(2'd0, 5'd3, pc);
    do_agu(pa, 32'h400); do_agu(pb, 32'h404); step(2);
    flush_valid = 1; flush_ptr = pa; step(1); flush_valid = 0;
    chk(alloc_ptr == pa, "R10 tail rolled back", alloc_ptr, pa);
    q0 = req_cnt; step(12);
    chk(res_cnt == r0, "R10 flushed load silent", res_cnt, r0);
    chk(req_cnt == q0, "R10 flushed entries never issue", req_cnt, q0);
    do_alloc(2'd0, 5'd9, pd); do_agu(pd, 32'h500); step(15);
    chk(res_cnt == r0 + 1 && last_rob == 5'd9, "R10 queue resumes", last_rob, 9);

    // Random mix, checked every cycle by the model.
    lsu_rand = 1;
    for (int c = 0; c < 4000; c++) begin
      int i;
      alloc_req = ($urandom % 3) == 0; alloc_kind = 2'($urandom % 3);
      alloc_size = 2'($urandom); alloc_rob = 5'($urandom);
      agu_we = 0;
      if (mq.size() > 0 && ($urandom % 2) == 1) begin
        i = $urandom_range(0, mq.size() - 1);
        if (!mq[i].vld) begin
          agu_we = 1; agu_slot = IDX_W'(mq[i].ptr % DEPTH);
          agu_addr = $urandom; agu_data = $urandom;
        end
      end
      if (mq.size() > 0 && ($urandom % 4) != 0) rob_head = mq[0].rob;
      else rob_head = 5'($urandom);
      flush_valid = 0;
      if (mq.size() > 0 && ($urandom % 50) == 0) begin
        flush_valid = 1;
        flush_ptr = PTR_W'((h_ptr + int'($urandom_range(0, mq.size()))) % PMOD);
      end
      step(1);
    end
    alloc_req = 0; agu_we = 0; flush_valid = 0; step(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule